// File: doc/BRIEF.md
# Four-Stage Pipelined 8-bit Processor Core

This core runs 16-bit instructions through four stages: fetch, decode, execute and writeback. It works on 8-bit data held in sixteen registers. The instruction store sits outside the core. The core drives a 7-bit fetch address and receives the instruction word in the same cycle. A 64-word data memory is inside the core, and no instruction carries a memory address. Register r14 always gives the memory address. Register r15 always gives the store data, and a load always writes its result into r15. A 4-bit port number selects a port on the external I/O buses. Conditional branches test one of four flags that the last arithmetic or logic instruction left behind.

Read-after-write hazards between neighbouring instructions are resolved in hardware, so no software padding is needed. The register file read in decode passes the value being written back straight through. Each execute operand has a mux that takes the result of the instruction one step older. Branches, register jumps and HALT resolve in execute. When one takes effect, the two younger instructions already fetched are discarded.

Top module: `pipe8_core`

## Requirements
- R1: While reset is held, and after it is released, imemAddr is 0, ioWr is 0 and halted is 0. All registers read as zero and all flags are clear. The first instruction fetched comes from address 0.
- R2: When no branch, jump or halt takes effect, imemAddr rises by one on every clock and wraps from 127 to 0.
- R3: An instruction word is {op[15:12], rd[11:8], rs1[7:4], rs2[3:0]}, and imm is bits [7:0]. The opcodes are:
  - op 1: rd = rs1 + rs2.
  - op 2: rd = rs1 - rs2.
  - op 3: rd = rd AND imm.
  - op 4: rd = rd + imm.
  - op 5: rd = rs1 XOR rs2.
  - op 6: rd = rs1 OR rs2.
  - Opcodes 0, 14 and 15 change no register, flag or output.
- R4: An instruction that reads a register written by the instruction just before it, or two before it, uses the newly written value.
- R5: Ops 1 to 6 update the flags, and no other instruction touches them. The flags are:
  - lsb = result bit 0.
  - msb = result bit 7.
  - zero = result is 0.
  - carry = carry out for ops 1 and 4; 1 when there is no borrow for op 2; 0 for ops 3, 5 and 6.
- R6: Op 7 is a branch, and its target is imm[6:0]. The rd field controls it:
  - Bit 3 set means the branch is always taken.
  - Otherwise it is taken when the selected flag XOR rd bit 2 is 1.
  - rd bits [1:0] select the flag: 0 lsb, 1 msb, 2 zero, 3 carry.
- R7: Op 8 jumps to the low 7 bits of register rs1.
- R8: A taken branch or jump puts its target on imemAddr on the next clock. The two younger instructions have no effect, so each taken transfer costs two cycles.
- R9: Op 9 asserts ioWr for exactly one cycle, with ioAddr = rs2 field and ioWrData = register rs1.
- R10: Op 10 writes into rd the value on ioRdData, while ioAddr = rs2 field.
- R11: Data memory:
  - Op 11 stores r15 into memory[r14 bits 5:0] and writes no register.
  - Op 12 loads memory[r14 bits 5:0] into r15.
- R12: Op 13 (HALT) sets halted on the clock edge that ends its execute cycle. After that, imemAddr stays frozen and no younger instruction takes effect. Older instructions still complete. A program of n executed instructions with k taken transfers raises halted on edge n+1+2k after reset release, counting that first edge as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | 7 | Instruction fetch address (program counter) |
| imemData | input | 16 | Instruction word at imemAddr, same cycle |
| ioAddr | output | 4 | Port number of the instruction in execute |
| ioWrData | output | 8 | Output port data |
| ioWr | output | 1 | Output port write strobe |
| ioRdData | input | 8 | Input port data for ioAddr |
| halted | output | 1 | Core has stopped on HALT |

## Verification
The following are checked on every cycle:
- The program counter steps by one whenever no transfer is pending.
- A taken transfer loads its target on the next clock.
- Both younger stages are empty after a transfer or halt.
- A store leaves the register write strobe low.
- A halted core keeps its address frozen and never strobes an output port.

Only the bench's programs can show that results are correct. This covers arithmetic values and flags, forwarding at distances one and two, flag selection with inversion, indirect memory access through r14 and r15, and port reads. It also covers the exact cycle at which halted rises, which shows the two-cycle transfer penalty.

// File: rtl/pipe8_pkg.sv
package pipe8_pkg;

  localparam int DATA_W = 8;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] MEM_ADDR_REG = 4'd14;
  localparam logic [REG_AW-1:0] MEM_DATA_REG = 4'd15;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_ANDI = 4'd3,
    OP_ADDI = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_BR   = 4'd7,
    OP_JR   = 4'd8,
    OP_OUT  = 4'd9,
    OP_IN   = 4'd10,
    OP_ST   = 4'd11,
    OP_LD   = 4'd12,
    OP_HALT = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_XOR,
    ALU_OR
  } aluop_e;

  // result source for writeback
  typedef enum logic [1:0] {
    RES_ALU,
    RES_PORT,
    RES_MEM
  } ressel_e;

  typedef struct packed {
    logic              valid;
    logic              regWe;
    logic              setFlags;
    logic              useImm;
    aluop_e            aluOp;
    ressel_e           resSel;
    logic              isBranch;
    logic              isJump;
    logic              isOut;
    logic              isStore;
    logic              isHalt;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
    logic [DATA_W-1:0] imm;
  } strobe_t;

endpackage

// File: rtl/pipe8_regfile.sv
module pipe8_regfile #(
  parameter int DATA_W = 8,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddrA,
  input  logic [AW-1:0]     raddrB,
  output logic [DATA_W-1:0] rdataA,
  output logic [DATA_W-1:0] rdataB
);
  localparam int DEPTH  = 1 << AW;
  localparam int NPORTS = 2;

  logic [AW-1:0]     portAddr [NPORTS];
  logic [DATA_W-1:0] portData [NPORTS];

  assign portAddr[0] = raddrA;
  assign portAddr[1] = raddrB;
  assign rdataA = portData[0];
  assign rdataB = portData[1];

  // one mirrored bank per read port, all sharing the write port
  for (genvar g = 0; g < NPORTS; g++) begin : gBank
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
        mem[waddr] <= wdata;
      end
    end

    // write-through: a value being written back is seen by decode at once
    always_comb begin
      if (we && (waddr == portAddr[g])) portData[g] = wdata;
      else                              portData[g] = mem[portAddr[g]];
    end
  end

endmodule

// File: rtl/pipe8_ctrl.sv
module pipe8_ctrl
  import pipe8_pkg::*;
#(
  parameter int PC_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] imemAddr,
  input  logic [15:0]     imemData,
  input  logic            redirect,
  input  logic [PC_W-1:0] redirTarget,
  input  logic            haltHit,
  output logic            halted,
  output strobe_t         dStr
);
  logic [PC_W-1:0] pc;
  logic [15:0]     fdInstr;
  logic            fdValid;

  assign imemAddr = pc;

  // fetch stage
  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      fdInstr <= '0;
      fdValid <= 1'b0;
      halted  <= 1'b0;
    end else if (halted || haltHit) begin
      halted  <= 1'b1;
      fdValid <= 1'b0;
    end else if (redirect) begin
      pc      <= redirTarget;
      fdValid <= 1'b0;
    end else begin
      fdInstr <= imemData;
      fdValid <= 1'b1;
      pc      <= pc + 1'b1;
    end
  end

  // decode stage: instruction word to strobe set
  always_comb begin
    dStr          = '0;
    dStr.valid    = fdValid;
    dStr.rd       = fdInstr[11:8];
    dStr.rs1      = fdInstr[7:4];
    dStr.rs2      = fdInstr[3:0];
    dStr.imm      = fdInstr[7:0];
    dStr.aluOp    = ALU_ADD;
    dStr.resSel   = RES_ALU;
    unique case (opcode_e'(fdInstr[15:12]))
      OP_ADD:  begin dStr.regWe = 1'b1; dStr.setFlags = 1'b1; dStr.aluOp = ALU_ADD; end
      OP_SUB:  begin dStr.regWe = 1'b1; dStr.setFlags = 1'b1; dStr.aluOp = ALU_SUB; end
      OP_XOR:  begin dStr.regWe = 1'b1; dStr.setFlags = 1'b1; dStr.aluOp = ALU_XOR; end
      OP_OR:   begin dStr.regWe = 1'b1; dStr.setFlags = 1'b1; dStr.aluOp = ALU_OR;  end
      OP_ANDI: begin
        dStr.regWe = 1'b1; dStr.setFlags = 1'b1; dStr.useImm = 1'b1;
        dStr.aluOp = ALU_AND; dStr.rs1 = fdInstr[11:8];
      end
      OP_ADDI: begin
        dStr.regWe = 1'b1; dStr.setFlags = 1'b1; dStr.useImm = 1'b1;
        dStr.aluOp = ALU_ADD; dStr.rs1 = fdInstr[11:8];
      end
      OP_BR:   dStr.isBranch = 1'b1;
      OP_JR:   dStr.isJump   = 1'b1;
      OP_OUT:  dStr.isOut    = 1'b1;
      OP_IN:   begin dStr.regWe = 1'b1; dStr.resSel = RES_PORT; end
      OP_ST:   begin
        dStr.isStore = 1'b1; dStr.rs1 = MEM_ADDR_REG; dStr.rs2 = MEM_DATA_REG;
      end
      OP_LD:   begin
        dStr.regWe = 1'b1; dStr.resSel = RES_MEM; dStr.rd = MEM_DATA_REG;
        dStr.rs1 = MEM_ADDR_REG; dStr.rs2 = MEM_DATA_REG;
      end
      OP_HALT: dStr.isHalt = 1'b1;
      default: ;
    endcase
  end

  // R2: sequential stepping when nothing redirects
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(redirect) && !$past(haltHit) && !$past(halted))
      |-> (pc == $past(pc) + 1'b1));

  // R8: a taken transfer loads its target on the next clock
  a_r8_redirect_target: assert property (@(posedge clk) disable iff (rst)
    (redirect && !halted) |=> (pc == $past(redirTarget)));

  // R12: a halted core stays halted with a frozen address and empty fetch
  a_r12_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && !fdValid));

endmodule

// File: rtl/pipe8_datapath.sv
module pipe8_datapath
  import pipe8_pkg::*;
#(
  parameter int PC_W   = 7,
  parameter int RAM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           dStr,
  input  logic [DATA_W-1:0] ioRdData,
  output logic              redirect,
  output logic [PC_W-1:0]   redirTarget,
  output logic              haltHit,
  output logic [REG_AW-1:0] ioAddr,
  output logic [DATA_W-1:0] ioWrData,
  output logic              ioWr
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  // flag vector positions: 0 lsb, 1 msb, 2 zero, 3 carry
  localparam int F_LSB = 0;
  localparam int F_MSB = 1;
  localparam int F_ZERO = 2;
  localparam int F_CARRY = 3;

  strobe_t           ex;
  logic [DATA_W-1:0] exA, exB;
  logic              ewWe;
  logic [REG_AW-1:0] ewRd;
  logic [DATA_W-1:0] ewData;
  logic [3:0]        flags;
  logic [DATA_W-1:0] mem [RAM_DEPTH];

  logic [DATA_W-1:0] rfA, rfB;
  logic [DATA_W-1:0] opA, opB, aluB, result;
  logic [DATA_W:0]   aluWide;
  logic [3:0]        newFlags;
  logic              brTaken, kill;
  strobe_t           dIn;

  pipe8_regfile #(.DATA_W(DATA_W), .AW(REG_AW)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (ewWe),
    .waddr  (ewRd),
    .wdata  (ewData),
    .raddrA (dStr.rs1),
    .raddrB (dStr.rs2),
    .rdataA (rfA),
    .rdataB (rfB)
  );

  // execute-stage forwarding from the instruction in writeback
  always_comb begin
    opA = (ewWe && (ewRd == ex.rs1)) ? ewData : exA;
    opB = (ewWe && (ewRd == ex.rs2)) ? ewData : exB;
    aluB = ex.useImm ? ex.imm : opB;
  end

  always_comb begin
    unique case (ex.aluOp)
      ALU_ADD: aluWide = {1'b0, opA} + {1'b0, aluB};
      ALU_SUB: aluWide = {1'b0, opA} + {1'b0, ~aluB} + 1'b1;
      ALU_AND: aluWide = {1'b0, opA & aluB};
      ALU_XOR: aluWide = {1'b0, opA ^ aluB};
      ALU_OR:  aluWide = {1'b0, opA | aluB};
      default: aluWide = '0;
    endcase
    newFlags[F_LSB]   = aluWide[0];
    newFlags[F_MSB]   = aluWide[DATA_W-1];
    newFlags[F_ZERO]  = (aluWide[DATA_W-1:0] == '0);
    newFlags[F_CARRY] = aluWide[DATA_W];
    unique case (ex.resSel)
      RES_PORT: result = ioRdData;
      RES_MEM:  result = mem[opA[RAM_AW-1:0]];
      default:  result = aluWide[DATA_W-1:0];
    endcase
  end

  // transfer resolution
  always_comb begin
    brTaken     = ex.rd[3] | (flags[ex.rd[1:0]] ^ ex.rd[2]);
    redirect    = ex.valid && ((ex.isBranch && brTaken) || ex.isJump);
    redirTarget = ex.isJump ? opA[PC_W-1:0] : ex.imm[PC_W-1:0];
    haltHit     = ex.valid && ex.isHalt;
    kill        = redirect || haltHit;
    dIn         = dStr;
    dIn.valid   = dStr.valid && !kill;
  end

  assign ioAddr   = ex.rs2;
  assign ioWrData = opA;
  assign ioWr     = ex.valid && ex.isOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex     <= '0;
      exA    <= '0;
      exB    <= '0;
      ewWe   <= 1'b0;
      ewRd   <= '0;
      ewData <= '0;
      flags  <= '0;
    end else begin
      ex     <= dIn;
      exA    <= rfA;
      exB    <= rfB;
      ewWe   <= ex.valid && ex.regWe;
      ewRd   <= ex.rd;
      ewData <= result;
      if (ex.valid && ex.setFlags) flags <= newFlags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && ex.valid && ex.isStore) mem[opA[RAM_AW-1:0]] <= opB;
  end

  // R8: both younger stages are empty after a transfer or halt
  a_r8_flush_kills: assert property (@(posedge clk) disable iff (rst)
    (redirect || haltHit) |=> !ex.valid);

  // R11: a store never reaches the register write port
  a_r11_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
    (ex.valid && ex.isStore) |=> !ewWe);

endmodule

// File: rtl/pipe8_core.sv
module pipe8_core
  import pipe8_pkg::*;
#(
  parameter int PC_W   = 7,
  parameter int RAM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   imemAddr,
  input  logic [15:0]       imemData,
  output logic [REG_AW-1:0] ioAddr,
  output logic [DATA_W-1:0] ioWrData,
  output logic              ioWr,
  input  logic [DATA_W-1:0] ioRdData,
  output logic              halted
);
  strobe_t         dStr;
  logic            redirect, haltHit;
  logic [PC_W-1:0] redirTarget;

  pipe8_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .imemAddr    (imemAddr),
    .imemData    (imemData),
    .redirect    (redirect),
    .redirTarget (redirTarget),
    .haltHit     (haltHit),
    .halted      (halted),
    .dStr        (dStr)
  );

  pipe8_datapath #(.PC_W(PC_W), .RAM_AW(RAM_AW)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .dStr        (dStr),
    .ioRdData    (ioRdData),
    .redirect    (redirect),
    .redirTarget (redirTarget),
    .haltHit     (haltHit),
    .ioAddr      (ioAddr),
    .ioWrData    (ioWrData),
    .ioWr        (ioWr)
  );

  // R12: no port write once halted
  a_r12_halted_no_io: assert property (@(posedge clk) disable iff (rst)
    halted |-> !ioWr);

endmodule

// File: tb/pipe8_core_bench.sv
module pipe8_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  imemAddr;
  logic [15:0] imemData;
  logic [3:0]  ioAddr;
  logic [7:0]  ioWrData, ioRdData;
  logic        ioWr, halted;

  always #2 clk = ~clk;

  logic [15:0] rom [128];
  assign imemData = rom[imemAddr];
  assign ioRdData = {ioAddr, ioAddr ^ 4'hA};

  pipe8_core u_pipe8_core (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr),
    .ioRdData(ioRdData), .halted(halted)
  );

  int          nChecks = 0;
  int          nFails  = 0;
  bit          finished = 0;
  string       tag;
  logic [11:0] expQ [$];
  logic [7:0]  mreg [16];
  logic [7:0]  mram [64];
  logic [3:0]  mflags;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rr(int op, int rd, int a, int b);
    return {op[3:0], rd[3:0], a[3:0], b[3:0]};
  endfunction

  function automatic logic [15:0] ri(int op, int rd, int imm);
    return {op[3:0], rd[3:0], imm[7:0]};
  endfunction

  function automatic logic [7:0] portVal(logic [3:0] p);
    return {p, p ^ 4'hA};
  endfunction

  task automatic clearRom();
    for (int i = 0; i < 128; i++) rom[i] = 16'h0000;
  endtask

  // behavioural instruction-level model: fills expQ, counts instructions and transfers
  task automatic model(output int n, output int k);
    int  pc;
    bit  done;
    pc = 0; done = 0; n = 0; k = 0;
    for (int i = 0; i < 16; i++) mreg[i] = 8'h00;
    mflags = 4'h0;
    expQ.delete();
    while (!done && n < 2000) begin
      logic [15:0] w;
      logic [3:0]  op, rd, a, b;
      logic [7:0]  im;
      logic [8:0]  t;
      int          nxt;
      bit          fl;
      w = rom[pc]; op = w[15:12]; rd = w[11:8]; a = w[7:4]; b = w[3:0]; im = w[7:0];
      nxt = (pc + 1) % 128;
      t = 9'h000;
      fl = 0;
      case (op)
        4'd1: begin t = {1'b0, mreg[a]} + {1'b0, mreg[b]}; fl = 1; end
        4'd2: begin t = {1'b0, mreg[a]} + {1'b0, ~mreg[b]} + 9'd1; fl = 1; end
        4'd3: begin t = {1'b0, mreg[rd] & im}; fl = 1; end
        4'd4: begin t = {1'b0, mreg[rd]} + {1'b0, im}; fl = 1; end
        4'd5: begin t = {1'b0, mreg[a] ^ mreg[b]}; fl = 1; end
        4'd6: begin t = {1'b0, mreg[a] | mreg[b]}; fl = 1; end
        4'd7: if (rd[3] || (mflags[rd[1:0]] ^ rd[2])) begin nxt = im[6:0]; k++; end
        4'd8: begin nxt = mreg[a][6:0]; k++; end
        4'd9: expQ.push_back({b, mreg[a]});
        4'd10: mreg[rd] = portVal(b);
        4'd11: mram[mreg[14][5:0]] = mreg[15];
        4'd12: mreg[15] = mram[mreg[14][5:0]];
        4'd13: done = 1;
        default: ;
      endcase
      if (fl) begin
        mreg[rd] = t[7:0];
        mflags = {t[8], t[7:0] == 8'h00, t[7], t[0]};
      end
      n++;
      pc = nxt;
    end
  endtask

  // port-write monitor compared on every clock
  always @(negedge clk) begin
    if (!rst && ioWr) begin
      if (expQ.size() == 0) begin
        check(1'b0, tag, "unexpected port write", {ioAddr, ioWrData}, 0);
      end else begin
        logic [11:0] e;
        e = expQ.pop_front();
        check({ioAddr, ioWrData} == e, tag, "port write {addr,data}", {ioAddr, ioWrData}, e);
      end
    end
  end

  task automatic runProg(bit checkStep);
    int n, k, e;
    logic [6:0] frozen;
    model(n, k);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(imemAddr == 7'd0, "R1", "reset imemAddr", imemAddr, 0);
    check(ioWr == 1'b0 && halted == 1'b0, "R1", "reset ioWr/halted", {ioWr, halted}, 0);
    rst = 1'b0;
    e = -1;
    while (!halted && e < 3000) begin
      @(negedge clk);
      e++;
      if (checkStep && e < 3)
        check(imemAddr == 7'(e + 1), "R2", "sequential imemAddr", imemAddr, e + 1);
    end
    check(e == n + 1 + 2 * k, {tag, " R8 R12"}, "halt edge", e, n + 1 + 2 * k);
    frozen = imemAddr;
    repeat (4) @(negedge clk);
    check(halted && imemAddr == frozen, "R12", "frozen after halt", imemAddr, frozen);
    check(expQ.size() == 0, tag, "port writes left unseen", expQ.size(), 0);
  endtask

  initial begin
    // program A: arithmetic, logic, forwarding, ignored opcodes
    clearRom();
    rom[0]  = ri(4, 1, 8'h05);
    rom[1]  = ri(4, 2, 8'h03);
    rom[2]  = rr(1, 3, 1, 2);
    rom[3]  = rr(2, 4, 3, 1);
    rom[4]  = rr(5, 5, 4, 3);
    rom[5]  = rr(6, 6, 5, 1);
    rom[6]  = ri(3, 6, 8'h0C);
    rom[7]  = 16'hE3FF;
    rom[8]  = 16'hF6FF;
    rom[9]  = rr(9, 0, 3, 1);
    rom[10] = rr(9, 0, 4, 2);
    rom[11] = rr(9, 0, 5, 3);
    rom[12] = rr(9, 0, 6, 4);
    rom[13] = ri(4, 7, 8'hFF);
    rom[14] = ri(4, 7, 8'h01);
    rom[15] = rr(9, 0, 7, 5);
    rom[16] = rr(2, 8, 1, 2);
    rom[17] = rr(2, 9, 2, 1);
    rom[18] = rr(9, 0, 8, 6);
    rom[19] = rr(9, 0, 9, 7);
    rom[20] = 16'h0000;
    rom[21] = rr(9, 0, 3, 8);
    rom[22] = 16'hD000;
    tag = "R3 R4";
    runProg(1'b1);

    // program B: flag selection, inversion, flush of shadow instructions
    clearRom();
    rom[0]  = ri(4, 1, 8'h81);
    rom[1]  = ri(7, 4'b0000, 8);
    rom[2]  = rr(9, 0, 1, 15);
    rom[3]  = rr(9, 0, 1, 15);
    rom[8]  = rr(9, 0, 1, 1);
    rom[9]  = ri(7, 4'b0010, 40);
    rom[10] = rr(9, 0, 1, 2);
    rom[11] = ri(4, 2, 8'h00);
    rom[12] = ri(7, 4'b0110, 40);
    rom[13] = rr(9, 0, 1, 3);
    rom[14] = ri(7, 4'b0111, 20);
    rom[15] = rr(9, 0, 1, 15);
    rom[16] = rr(9, 0, 1, 15);
    rom[20] = ri(4, 3, 8'hFF);
    rom[21] = ri(4, 3, 8'h01);
    rom[22] = ri(7, 4'b0011, 26);
    rom[23] = rr(9, 0, 3, 15);
    rom[24] = rr(9, 0, 3, 15);
    rom[26] = ri(7, 4'b0001, 40);
    rom[27] = rr(9, 0, 3, 4);
    rom[28] = ri(7, 4'b1000, 32);
    rom[29] = rr(9, 0, 1, 15);
    rom[30] = rr(9, 0, 1, 15);
    rom[32] = rr(9, 0, 1, 5);
    rom[33] = ri(7, 4'b0101, 36);
    rom[34] = rr(9, 0, 1, 15);
    rom[35] = rr(9, 0, 1, 15);
    rom[36] = 16'hD000;
    rom[40] = rr(9, 0, 1, 14);
    rom[41] = 16'hD000;
    tag = "R5 R6";
    runProg(1'b0);

    // program C: memory through r14/r15, port reads, register jumps
    clearRom();
    rom[0]  = ri(4, 14, 8'h05);
    rom[1]  = ri(4, 15, 8'h3C);
    rom[2]  = 16'hB000;
    rom[3]  = ri(4, 14, 8'h06);
    rom[4]  = ri(4, 15, 8'h11);
    rom[5]  = 16'hB000;
    rom[6]  = ri(4, 14, 8'hFA);
    rom[7]  = 16'hC000;
    rom[8]  = rr(9, 0, 15, 1);
    rom[9]  = ri(4, 14, 8'h06);
    rom[10] = 16'hC000;
    rom[11] = rr(9, 0, 15, 2);
    rom[12] = rr(10, 8, 0, 3);
    rom[13] = rr(9, 0, 8, 3);
    rom[14] = ri(4, 9, 30);
    rom[15] = rr(8, 0, 9, 0);
    rom[16] = rr(9, 0, 9, 15);
    rom[17] = rr(9, 0, 9, 15);
    rom[30] = rr(10, 10, 0, 9);
    rom[31] = rr(1, 11, 10, 8);
    rom[32] = rr(9, 0, 11, 4);
    rom[33] = 16'hB300;
    rom[34] = rr(9, 0, 3, 5);
    rom[35] = ri(4, 12, 8'hC8);
    rom[36] = rr(8, 0, 12, 0);
    rom[37] = rr(9, 0, 12, 15);
    rom[38] = rr(9, 0, 12, 15);
    rom[72] = ri(4, 14, 8'h40);
    rom[73] = 16'hC000;
    rom[74] = rr(9, 0, 15, 7);
    rom[75] = rr(9, 0, 12, 6);
    rom[76] = 16'hD000;
    tag = "R7 R9 R10 R11";
    runProg(1'b0);

    // program D: a lone HALT
    clearRom();
    rom[0] = 16'hD000;
    tag = "R12";
    runProg(1'b0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule